// File: doc/BRIEF.md
# Serial Shift Front-End with Readback

This block is the receive and readback path for a three-wire serial control port. While the active-low select line is low, each rising edge of the serial clock shifts one data bit into a 16-bit register. The register fills from its least significant end, so the first bit sent ends up in bit 15. When the select line returns high, the register value is copied to a word output and a one-cycle strobe tells a downstream command decoder that a new word is ready. The top three bits of the word are the command field. The lower thirteen bits are the data field.

The register's top bit is driven out on a serial output pin, so devices can be daisy-chained and their contents read back. A mode input picks the launch edge. With the mode low, the output moves on falling serial-clock edges and trails the input by sixteen clocks. With the mode high, it moves on rising edges and trails by fifteen and a half clocks. A freeze input models shutdown: the serial output keeps its level, while shifting and word capture go on as normal.

All serial pins are brought into the system clock domain through two-flop synchronisers and edge-detected there. The system clock must run at least four times faster than the serial clock.

Top module: `serial_frontend`

## Requirements
- R1: A rising serial-clock edge seen while the select line is high leaves the register unchanged. A later frame with no clocks presents the same word as before.
- R2: Bits are sent MSB first. The first bit of a 16-clock frame appears in word bit 15, and the command field is bits 15..13. The last bit appears in word bit 0, and the data field is bits 12..0.
- R3: A rising edge on the select line updates the word output and raises the strobe for exactly one system clock. The word output holds its value between strobes.
- R4: A frame sent as two 8-bit bursts, with the select line held low through the gap, gives the same word as a frame sent without a gap.
- R5: With the mode input low, the serial output changes only on falling serial-clock edges. After each falling edge it equals the register's top bit, so it lags the input by 16 clocks.
- R6: With the mode input high, the serial output changes on rising serial-clock edges. After each rising edge it equals the newly shifted top bit, so it lags the input by 15.5 clocks.
- R7: While the freeze input is high, the serial output keeps its level. Shifting, word capture and the strobe continue unchanged.
- R8: A frame of any length other than 16 clocks presents the last 16 bits held in the register, older bits included. No error is flagged.
- R9: After reset the word output, the strobe, the serial output and the register are all zero.
- R10: The serial output does not change while the select line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_in | input | 1 | Serial data input |
| rise_launch | input | 1 | 0: serial output moves on falling edges; 1: on rising edges |
| dout_freeze | input | 1 | Holds the serial output (shutdown) |
| ser_out | output | 1 | Serial data output for chaining and readback |
| frame_word | output | 16 | Last captured word; bits 15..13 command, 12..0 data |
| frame_strobe | output | 1 | One-cycle pulse when frame_word is updated |

## Verification
Two functions can land in the same system-clock cycle. One is a rising serial-clock edge that shifts the register and, in rise-launch mode, also updates the serial output from the same pre-shift value. The other is a freeze that begins while the output is still being updated. The bench provokes the first by running many rise-launch frames and sampling the output half a serial period after each edge, where it must equal the newly shifted top bit rather than the stale one. It provokes the second by raising the freeze between random frames and then checking that the output stays at its last level while the captured words still match the bench's own shadow register.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 3;
  localparam int DATA_W = WORD_W - CMD_W;

  typedef logic [WORD_W-1:0] word_t;

  // shift one bit in at the LSB end
  function automatic word_t shift_in(input word_t r, input logic b);
    return {r[WORD_W-2:0], b};
  endfunction

  // bit driven out when launching on a falling edge
  function automatic logic top_bit(input word_t r);
    return r[WORD_W-1];
  endfunction

  // bit that becomes the top after the next shift (rising-edge launch)
  function automatic logic next_top_bit(input word_t r);
    return r[WORD_W-2];
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_edges.sv
module sfe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic sel_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_rise,
  output logic active
);
  logic sclk_d, sel_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sel_n_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      sel_n_d <= sel_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign sel_rise  = sel_n_s & ~sel_n_d;
  assign active    = ~sel_n_s;
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift
  import sfe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  din_bit,
  input  logic  sel_rise,
  output word_t shreg,
  output word_t word_out,
  output logic  word_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      if (shift_en) shreg <= shift_in(shreg, din_bit);
      word_valid <= sel_rise;
      if (sel_rise) word_out <= shreg;
    end
  end

  // R1: no shifting outside an active clock edge
  p_no_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shreg));
  // R3: strobe is a single cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R3: word holds between strobes
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out));
endmodule

// File: rtl/sfe_dout.sv
module sfe_dout (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic active,
  input  logic mode_rise,
  input  logic freeze,
  input  logic cur_top,
  input  logic nxt_top,
  output logic dout
);
  logic launch_ev;
  logic launch_val;

  assign launch_ev  = active & ~freeze & (mode_rise ? rise_ev : fall_ev);
  assign launch_val = mode_rise ? nxt_top : cur_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else if (launch_ev) dout <= launch_val;
  end

  // R5 / R6: output moves only on the selected serial edge
  p_launch_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(mode_rise) ? $past(rise_ev) : $past(fall_ev)));
  // R7: frozen output holds
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freeze) |-> $stable(dout));
  // R10: no change while deselected
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(active));
endmodule

// File: rtl/serial_frontend.sv
module serial_frontend
  import sfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_in,
  input  logic              rise_launch,
  input  logic              dout_freeze,
  output logic              ser_out,
  output logic [WORD_W-1:0] frame_word,
  output logic              frame_strobe
);
  logic [1:0] cd_s;
  logic       sel_n_s;
  logic       sclk_rise, sclk_fall, sel_rise, active;
  word_t      shreg;

  // serial clock and data travel through matched stages
  sfe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_cd (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_in}), .q(cd_s));

  sfe_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(ser_sel_n), .q(sel_n_s));

  sfe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sclk_s(cd_s[1]), .sel_n_s(sel_n_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel_rise(sel_rise),
    .active(active));

  sfe_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise & active),
    .din_bit(cd_s[0]), .sel_rise(sel_rise), .shreg(shreg),
    .word_out(frame_word), .word_valid(frame_strobe));

  sfe_dout u_dout (
    .clk(clk), .rst_n(rst_n), .rise_ev(sclk_rise), .fall_ev(sclk_fall),
    .active(active), .mode_rise(rise_launch), .freeze(dout_freeze),
    .cur_top(top_bit(shreg)), .nxt_top(next_top_bit(shreg)), .dout(ser_out));
endmodule

// File: tb/serial_frontend_test.sv
module serial_frontend_test;
  localparam int HALF = 6; // system clocks per serial half period

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_sel_n = 1, ser_in = 0, rise_launch = 0, dout_freeze = 0;
  logic ser_out, frame_strobe;
  logic [15:0] frame_word;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] shadow = '0;   // bench model of the register
  logic        exp_out = 0;

  serial_frontend uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial bit; active=1 when select is low
  task automatic send_bit(input logic b);
    bit act;
    act = !ser_sel_n;
    ser_in = b;
    wclk(HALF);
    ser_clk = 1;
    if (act) shadow = {shadow[14:0], b};
    if (act && rise_launch && !dout_freeze) exp_out = shadow[15];
    wclk(HALF);
    chk(ser_out === exp_out, rise_launch ? "R6 rise" : "R5 after-rise", {15'd0, ser_out}, {15'd0, exp_out});
    if (!act) chk(ser_out === exp_out, "R10", {15'd0, ser_out}, {15'd0, exp_out});
    ser_clk = 0;
    if (act && !rise_launch && !dout_freeze) exp_out = shadow[15];
    wclk(HALF);
    chk(ser_out === exp_out, dout_freeze ? "R7" : (rise_launch ? "R6 after-fall" : "R5 fall"),
        {15'd0, ser_out}, {15'd0, exp_out});
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input bit split, input string req);
    int pulses;
    logic [15:0] got;
    ser_sel_n = 0;
    wclk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(bits[i]);
      if (split && (n - i) == 8) wclk(20);
    end
    ser_sel_n = 1;
    pulses = 0;
    got = frame_word;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (frame_strobe) begin pulses++; got = frame_word; end
    end
    chk(pulses == 1, "R3 strobe", 16'(pulses), 16'd1);
    chk(got === shadow, req, got, shadow);
    chk(frame_word === shadow, "R3 hold", frame_word, shadow);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    void'($urandom(32'h5eed1234));
    wclk(3);
    // R9 reset values
    chk(frame_word === 16'd0, "R9 word", frame_word, 16'd0);
    chk(frame_strobe === 1'b0, "R9 strobe", {15'd0, frame_strobe}, 16'd0);
    chk(ser_out === 1'b0, "R9 out", {15'd0, ser_out}, 16'd0);
    rst_n = 1;
    wclk(4);
    // R9: empty frame shows zero register
    frame(32'd0, 0, 0, "R9 reg");
    // R2 MSB first: command 3'b101 data 13'h0A5A
    frame({16'd0, 3'b101, 13'h0A5A}, 16, 0, "R2 field order");
    chk(frame_word[15:13] === 3'b101, "R2 cmd", {13'd0, frame_word[15:13]}, 16'd5);
    // R1 edges with select high ignored
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    frame(32'd0, 0, 0, "R1 idle edges");
    // R4 split vs continuous
    a = 16'hC3A7;
    frame({16'd0, a}, 16, 1, "R4 split");
    chk(frame_word === a, "R4 value", frame_word, a);
    // R6 mode 1
    rise_launch = 1;
    frame({16'd0, 16'h8001}, 16, 0, "R6 frame");
    // R8 short and long frames
    frame({24'd0, 8'h5B}, 8, 0, "R8 short");
    rise_launch = 0;
    frame(32'hFF00_3CE1, 24, 0, "R8 long");
    // R7 freeze
    dout_freeze = 1;
    b = ~shadow;
    frame({16'd0, b}, 16, 0, "R7 capture");
    dout_freeze = 0;
    // random mix
    for (int k = 0; k < 30; k++) begin
      int len;
      len = ($urandom % 4 == 0) ? 8 + ($urandom % 17) : 16;
      rise_launch = $urandom % 2;
      dout_freeze = ($urandom % 5 == 0);
      frame($urandom, len, $urandom % 2, len == 16 ? "R2 random" : "R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule